// File: doc/BRIEF.md
# Address Bus Tenure Master Controller

This block runs the master side of the address phase on a split-transaction system bus. A requester presents an address and an attribute word and raises a request. Once the block samples a qualified grant, it starts a tenure on the next clock. In that clock it pulses the transfer-start strobe for one cycle, raises address-bus-busy and drives the captured address and attributes. It holds busy and the address lines until an external address acknowledge ends the tenure. The acknowledge is accepted no earlier than the clock after the strobe, and the agent may hold it off for any number of clocks.

A retry input that arrives together with the acknowledge sets a sticky flag for the requester, and the tenure still ends normally. Reissuing the transfer is left to the requester. While the block is idle it watches address tenures that other masters start. It accepts their start strobe in the same clock as their busy assertion or in any later clock, and it refuses grants until the observed tenure has been acknowledged.

Top module: `abus_tenure_ctl`

## Requirements
- R1: After reset, ts_o, busy_o, done_o, retry_pend_o and obs_active_o are 0 and addr_o and attr_o are all zeros.
- R2: When req_i and grant_i are sampled high at a rising edge while the block is idle, busy_in_i is low and no foreign tenure is being observed, ts_o and busy_o go high in the next clock. In that clock addr_o and attr_o equal req_addr_i and req_attr_i as sampled at that edge, and they ignore later changes of those inputs.
- R3: ts_o is high for exactly one clock per tenure and never rises again before busy_o has fallen.
- R4: ack_i sampled in the clock where ts_o is high has no effect. The tenure continues and busy_o stays high.
- R5: busy_o, addr_o and attr_o hold steady from the strobe clock through the clock in which ack_i is sampled high. busy_o is low in the following clock, so each clock of delay before the acknowledge lengthens busy by one clock.
- R6: done_o is high for exactly the one clock that follows the clock in which a tenure's acknowledge was sampled.
- R7: When retry_i is high in the clock in which the acknowledge is accepted, retry_pend_o goes high with done_o. It stays high while idle and clears in the strobe clock of the next tenure. retry_i without an acknowledge does not set it.
- R8: No tenure starts from a grant sampled while busy_in_i is high, while a foreign tenure is being observed, or while the block's own tenure is in progress.
- R9: While idle, ts_in_i sampled high together with busy_in_i makes obs_active_o high in the next clock, whether busy_in_i rose in that clock or earlier. obs_active_o falls in the clock after ack_i is sampled high. ts_in_i with busy_in_i low is ignored.
- R10: addr_o and attr_o are all zeros whenever busy_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Requester wants an address tenure |
| req_addr_i | input | AW | Address to place on the bus |
| req_attr_i | input | TW | Transfer attribute word |
| grant_i | input | 1 | Bus grant from the arbiter |
| ack_i | input | 1 | Address acknowledge, ends the current tenure |
| retry_i | input | 1 | Retry indication sampled with the acknowledge |
| ts_in_i | input | 1 | Transfer-start strobe of another master |
| busy_in_i | input | 1 | Address-bus-busy driven by another master |
| ts_o | output | 1 | Transfer-start strobe, one clock |
| busy_o | output | 1 | Address-bus-busy for the own tenure |
| addr_o | output | AW | Driven address, zero when not master |
| attr_o | output | TW | Driven attributes, zero when not master |
| done_o | output | 1 | One-clock pulse after the own tenure ends |
| retry_pend_o | output | 1 | Sticky: last tenure was retried |
| obs_active_o | output | 1 | A foreign address tenure is in progress |

## Verification
The bench drives an acknowledge in the strobe clock itself. A design that ends the tenure on it shows a one-clock busy window, which the scoreboard's length check catches. Acknowledges held off for several clocks check that busy and the address stay put. Scrambling the request inputs after the grant shows whether the address was latched or passed through. Retry pulses without an acknowledge, and a retried tenure followed by a clean one, expose a flag that is set too eagerly or never cleared. Grants are offered during foreign busy, during an observed tenure and during the block's own tenure, so a design that starts a second tenure shows up as an unexpected strobe. Foreign strobes are sent in the busy-rise clock, two clocks after it, and without busy, which catches an observer tied to the busy edge.

// File: rtl/abt_pkg.sv
package abt_pkg;
    typedef enum logic [1:0] {
        MST_IDLE  = 2'd0,
        MST_START = 2'd1,
        MST_WAIT  = 2'd2
    } mst_state_e;
endpackage

// File: rtl/abt_grant_qual.sv
module abt_grant_qual (
    input  logic req_i,
    input  logic grant_i,
    input  logic busy_in_i,
    input  logic obs_active_i,
    input  logic mst_idle_i,
    output logic qual_o
);
    // A grant counts only when the bus is free of every tenure we know of.
    always_comb begin
        qual_o = req_i & grant_i & mst_idle_i & ~busy_in_i & ~obs_active_i;
    end
endmodule

// File: rtl/abt_master_fsm.sv
module abt_master_fsm
    import abt_pkg::*;
#(
    parameter int AW = 32,
    parameter int TW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          qual_i,
    input  logic [AW-1:0] req_addr_i,
    input  logic [TW-1:0] req_attr_i,
    input  logic          ack_i,
    input  logic          retry_i,
    output logic          ts_o,
    output logic          busy_o,
    output logic          idle_o,
    output logic [AW-1:0] addr_o,
    output logic [TW-1:0] attr_o,
    output logic          done_o,
    output logic          retry_pend_o
);
    typedef struct packed {
        mst_state_e    st;
        logic [AW-1:0] addr;
        logic [TW-1:0] attr;
        logic          done;
        logic          rty;
    } mst_regs_t;

    mst_regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            MST_IDLE: begin
                if (qual_i) begin
                    r_d.st   = MST_START;
                    r_d.addr = req_addr_i;
                    r_d.attr = req_attr_i;
                    r_d.rty  = 1'b0;
                end
            end
            MST_START: begin
                // Acknowledge is not accepted in the strobe clock.
                r_d.st = MST_WAIT;
            end
            MST_WAIT: begin
                if (ack_i) begin
                    r_d.st   = MST_IDLE;
                    r_d.addr = '0;
                    r_d.attr = '0;
                    r_d.done = 1'b1;
                    if (retry_i) begin
                        r_d.rty = 1'b1;
                    end
                end
            end
            default: begin
                r_d.st   = MST_IDLE;
                r_d.addr = '0;
                r_d.attr = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: MST_IDLE, addr: '0, attr: '0, done: 1'b0, rty: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        ts_o         = (r_q.st == MST_START);
        busy_o       = (r_q.st != MST_IDLE);
        idle_o       = (r_q.st == MST_IDLE);
        addr_o       = r_q.addr;
        attr_o       = r_q.attr;
        done_o       = r_q.done;
        retry_pend_o = r_q.rty;
    end
endmodule

// File: rtl/abt_observer.sv
module abt_observer (
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    input  logic ts_in_i,
    input  logic busy_in_i,
    input  logic ack_i,
    output logic active_o
);
    typedef struct packed {
        logic active;
    } obs_regs_t;

    obs_regs_t o_d, o_q;

    always_comb begin
        o_d = o_q;
        if (o_q.active) begin
            if (ack_i) begin
                o_d.active = 1'b0;
            end
        end else if (enable_i && ts_in_i && busy_in_i) begin
            // Strobe accepted with busy, whether busy rose now or earlier.
            o_d.active = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_q <= '{active: 1'b0};
        end else begin
            o_q <= o_d;
        end
    end

    assign active_o = o_q.active;
endmodule

// File: rtl/abus_tenure_ctl.sv
module abus_tenure_ctl
    import abt_pkg::*;
#(
    parameter int AW = 32,
    parameter int TW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_i,
    input  logic [AW-1:0] req_addr_i,
    input  logic [TW-1:0] req_attr_i,
    input  logic          grant_i,
    input  logic          ack_i,
    input  logic          retry_i,
    input  logic          ts_in_i,
    input  logic          busy_in_i,
    output logic          ts_o,
    output logic          busy_o,
    output logic [AW-1:0] addr_o,
    output logic [TW-1:0] attr_o,
    output logic          done_o,
    output logic          retry_pend_o,
    output logic          obs_active_o
);
    logic qual;
    logic mst_idle;

    abt_grant_qual u_qual (
        .req_i        (req_i),
        .grant_i      (grant_i),
        .busy_in_i    (busy_in_i),
        .obs_active_i (obs_active_o),
        .mst_idle_i   (mst_idle),
        .qual_o       (qual)
    );

    abt_master_fsm #(.AW(AW), .TW(TW)) u_mst (
        .clk          (clk),
        .rst_n        (rst_n),
        .qual_i       (qual),
        .req_addr_i   (req_addr_i),
        .req_attr_i   (req_attr_i),
        .ack_i        (ack_i),
        .retry_i      (retry_i),
        .ts_o         (ts_o),
        .busy_o       (busy_o),
        .idle_o       (mst_idle),
        .addr_o       (addr_o),
        .attr_o       (attr_o),
        .done_o       (done_o),
        .retry_pend_o (retry_pend_o)
    );

    abt_observer u_obs (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable_i  (mst_idle),
        .ts_in_i   (ts_in_i),
        .busy_in_i (busy_in_i),
        .ack_i     (ack_i),
        .active_o  (obs_active_o)
    );
endmodule

// File: rtl/abus_tenure_ctl_chk.sv
module abus_tenure_ctl_chk #(
    parameter int AW = 32,
    parameter int TW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ack_i,
    input logic          retry_i,
    input logic          ts_o,
    input logic          busy_o,
    input logic [AW-1:0] addr_o,
    input logic [TW-1:0] attr_o,
    input logic          done_o,
    input logic          retry_pend_o,
    input logic          obs_active_o
);
    p_strobe_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ts_o |=> !ts_o);

    p_strobe_in_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ts_o |-> busy_o);

    p_strobe_ack_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ts_o |=> busy_o);

    p_addr_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !ts_o) |-> ($stable(addr_o) && $stable(attr_o)));

    p_ack_releases_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !ts_o && ack_i) |=> (!busy_o && done_o));

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_retry_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !ts_o && ack_i && retry_i) |=> retry_pend_o);

    p_no_overlap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !obs_active_o);

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (addr_o == '0 && attr_o == '0));
endmodule

bind abus_tenure_ctl abus_tenure_ctl_chk #(.AW(AW), .TW(TW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ack_i        (ack_i),
    .retry_i      (retry_i),
    .ts_o         (ts_o),
    .busy_o       (busy_o),
    .addr_o       (addr_o),
    .attr_o       (attr_o),
    .done_o       (done_o),
    .retry_pend_o (retry_pend_o),
    .obs_active_o (obs_active_o)
);

// File: tb/abus_tenure_ctl_test.sv
module abus_tenure_ctl_test;
    localparam int AW = 32;
    localparam int TW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_i = 1'b0;
    logic [AW-1:0] req_addr_i = '0;
    logic [TW-1:0] req_attr_i = '0;
    logic          grant_i = 1'b0;
    logic          ack_i = 1'b0;
    logic          retry_i = 1'b0;
    logic          ts_in_i = 1'b0;
    logic          busy_in_i = 1'b0;
    logic          ts_o, busy_o, done_o, retry_pend_o, obs_active_o;
    logic [AW-1:0] addr_o;
    logic [TW-1:0] attr_o;

    int total = 0;
    int fails = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [AW-1:0] addr;
        logic [TW-1:0] attr;
        int            len;
    } exp_t;
    exp_t sbq[$];

    always #10 clk = ~clk;

    abus_tenure_ctl #(.AW(AW), .TW(TW)) uut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .req_addr_i(req_addr_i),
        .req_attr_i(req_attr_i), .grant_i(grant_i), .ack_i(ack_i),
        .retry_i(retry_i), .ts_in_i(ts_in_i), .busy_in_i(busy_in_i),
        .ts_o(ts_o), .busy_o(busy_o), .addr_o(addr_o), .attr_o(attr_o),
        .done_o(done_o), .retry_pend_o(retry_pend_o), .obs_active_o(obs_active_o)
    );

    task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", r, act, exp);
        end
    endtask

    // Monitor: compares strobes and busy windows against queued items.
    int  blen = 0;
    logic prev_ts = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (ts_o) begin
                chk("R3 strobe not repeated", {63'd0, prev_ts}, 64'd0);
                if (sbq.size() == 0) begin
                    chk("R8 strobe with no expected tenure", 64'd1, 64'd0);
                end else begin
                    chk("R2 address on strobe", addr_o, sbq[0].addr);
                    chk("R2 attributes on strobe", attr_o, sbq[0].attr);
                end
            end
            if (busy_o) begin
                blen++;
            end else if (blen > 0) begin
                if (sbq.size() > 0) begin
                    chk("R5 busy length", blen, sbq[0].len);
                    void'(sbq.pop_front());
                end
                chk("R10 address zero when idle", {attr_o, addr_o}, 64'd0);
                blen = 0;
            end
            prev_ts = ts_o;
        end
    end

    // Driver: one own tenure; early puts ack in the strobe clock (R4).
    task automatic tenure(input logic [AW-1:0] a, input logic [TW-1:0] t,
                          input int wait_n, input bit early, input bit rty,
                          input bit rty_noack, input bit keep_gnt);
        sbq.push_back('{addr: a, attr: t, len: wait_n + 2});
        @(negedge clk);
        req_i = 1'b1; grant_i = 1'b1; req_addr_i = a; req_attr_i = t;
        @(negedge clk);
        chk("R2 strobe after grant", {62'd0, ts_o, busy_o}, 64'd3);
        chk("R7 flag cleared at new strobe", {63'd0, retry_pend_o}, 64'd0);
        req_i = keep_gnt; grant_i = keep_gnt;
        req_addr_i = ~a; req_attr_i = ~t;
        ack_i = early;
        for (int i = 0; i < wait_n; i++) begin
            @(negedge clk);
            chk("R5 busy held while ack withheld", {62'd0, busy_o, ts_o}, 64'd2);
            ack_i = 1'b0; retry_i = rty_noack;
        end
        @(negedge clk);
        chk("R4 busy still high in ack clock", {63'd0, busy_o}, 64'd1);
        ack_i = 1'b1; retry_i = rty; req_i = 1'b0; grant_i = 1'b0;
        @(negedge clk);
        ack_i = 1'b0; retry_i = 1'b0;
        chk("R5 busy released after ack", {63'd0, busy_o}, 64'd0);
        chk("R6 done pulse", {63'd0, done_o}, 64'd1);
        chk("R7 retry flag", {63'd0, retry_pend_o}, {63'd0, rty});
        @(negedge clk);
        chk("R6 done one clock", {63'd0, done_o}, 64'd0);
        chk("R7 flag sticky while idle", {63'd0, retry_pend_o}, {63'd0, rty});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset outputs", {59'd0, ts_o, busy_o, done_o, retry_pend_o, obs_active_o}, 64'd0);
        chk("R1 reset address", {attr_o, addr_o}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        tenure(32'h1000_0040, 5'h0A, 0, 1'b0, 1'b0, 1'b0, 1'b0);
        tenure(32'hDEAD_BEE0, 5'h13, 0, 1'b1, 1'b0, 1'b0, 1'b0);
        tenure(32'h8000_0000, 5'h1F, 4, 1'b0, 1'b1, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        chk("R7 flag still set after idle", {63'd0, retry_pend_o}, 64'd1);
        tenure(32'h0000_1234, 5'h01, 3, 1'b0, 1'b0, 1'b1, 1'b1);
        tenure(32'hFFFF_FFFC, 5'h00, 1, 1'b1, 1'b0, 1'b0, 1'b0);

        // R8: grant while another master holds busy
        @(negedge clk);
        busy_in_i = 1'b1; req_i = 1'b1; grant_i = 1'b1;
        @(negedge clk);
        req_i = 1'b0; grant_i = 1'b0;
        @(negedge clk);
        chk("R8 no strobe under foreign busy", {62'd0, ts_o, busy_o}, 64'd0);

        // R9: strobe two clocks after busy rose
        ts_in_i = 1'b1;
        @(negedge clk);
        ts_in_i = 1'b0; busy_in_i = 1'b0;
        chk("R9 observer tracks late strobe", {63'd0, obs_active_o}, 64'd1);
        req_i = 1'b1; grant_i = 1'b1;
        @(negedge clk);
        chk("R8 no strobe while observing", {62'd0, ts_o, busy_o}, 64'd0);
        req_i = 1'b0; grant_i = 1'b0; ack_i = 1'b1;
        @(negedge clk);
        ack_i = 1'b0;
        chk("R9 observer released by ack", {63'd0, obs_active_o}, 64'd0);

        // R9: strobe in the same clock as busy rises
        busy_in_i = 1'b1; ts_in_i = 1'b1;
        @(negedge clk);
        ts_in_i = 1'b0;
        chk("R9 observer tracks strobe with busy", {63'd0, obs_active_o}, 64'd1);
        busy_in_i = 1'b0; ack_i = 1'b1;
        @(negedge clk);
        ack_i = 1'b0;
        chk("R9 observer cleared", {63'd0, obs_active_o}, 64'd0);

        // R9: strobe without busy is ignored
        ts_in_i = 1'b1;
        @(negedge clk);
        ts_in_i = 1'b0;
        chk("R9 strobe without busy ignored", {63'd0, obs_active_o}, 64'd0);

        tenure(32'h0BAD_F00C, 5'h15, 2, 1'b0, 1'b0, 1'b0, 1'b0);
        repeat (2) @(negedge clk);
        chk("R5 scoreboard drained", sbq.size(), 64'd0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule